// File: doc/BRIEF.md
# Condition Flag and Predication Unit

This unit keeps the processor's four status flags (negative, zero, carry, overflow) and decides, each cycle, whether the instruction being executed is allowed to take effect. Every instruction word carries a 4-bit condition code in its top nibble. The unit tests that code against the flags that are currently stored. If the test fails, the instruction becomes a no-op: it writes no register and leaves the flags untouched. This lets a compiler skip a single instruction without spending a branch on it.

When an instruction commits and asks for a flag update, the unit loads the flags from the ALU result, carry and overflow at the next clock edge. Compare-type instructions always update the flags and never write their destination register. The condition test is combinational on the stored flags. So a flag value written by one instruction decides whether the next cycle's instruction commits.

Top module: `flagpred_top`

## Requirements
- R1: A synchronous active-high reset clears all four flags. `flags_o` is 4'b0000 in the cycle after reset is sampled.
- R2: Only bits 31:28 of `instr_word` choose the condition. The other 28 bits have no effect on `commit_en`, `reg_we` or the flags.
- R3: The condition codes test the flags as follows: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z.
- R4: Code 1110 always commits. Code 1111 never commits.
- R5: The signed codes test: 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V).
- R6: A committed instruction with `set_flags`=1 loads the flags at the next edge. The new values are N = `alu_result[31]`, Z = (`alu_result`==0), C = `alu_carry`, V = `alu_ovf`.
- R7: With `cmp_only`=1, `reg_we` is 0. If the condition passes, the flags are loaded as in R6 whether or not `set_flags` is high.
- R8: `reg_we` is 1 exactly when the condition passes and `cmp_only` is 0. `commit_en` equals the condition result.
- R9: An instruction whose condition fails changes no flag, even with `set_flags` or `cmp_only` high.
- R10: A committed instruction with `set_flags`=0 and `cmp_only`=0 leaves the flags unchanged.
- R11: Flags written by one instruction decide the commit of the instruction presented in the next cycle.
- R12: `flags_o` shows the stored flags in the order {N,Z,C,V}, with N in bit 3 and V in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 32 | Current instruction; the condition code is in bits 31:28 |
| alu_result | input | 32 | ALU result of the current instruction |
| alu_carry | input | 1 | ALU carry out |
| alu_ovf | input | 1 | ALU signed overflow |
| set_flags | input | 1 | The instruction asks for a flag update |
| cmp_only | input | 1 | Compare-type instruction: update the flags, no register write |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |
| commit_en | output | 1 | The condition passed; the instruction takes effect |
| reg_we | output | 1 | Destination register write enable |

## Verification
Predication and flag update can both be active in the same cycle. An instruction's own condition is tested against the old flags while it also asks to load new ones. The bench provokes this with flag-setting and compare instructions whose condition fails. The flags must stay exactly as they were and `reg_we` must stay low. The bench also runs back-to-back pairs where the second instruction's code depends on the value the first just wrote. Its commit is judged against a flag model held in the bench.

// File: rtl/flagpred_pkg.sv
package flagpred_pkg;

  // Stored status flags, packed so that n is the most significant bit.
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Condition codes; odd codes are the negation of the even code below them.
  typedef enum logic [3:0] {
    CND_EQ = 4'h0, CND_NE = 4'h1, CND_CS = 4'h2, CND_CC = 4'h3,
    CND_MI = 4'h4, CND_PL = 4'h5, CND_VS = 4'h6, CND_VC = 4'h7,
    CND_HI = 4'h8, CND_LS = 4'h9, CND_GE = 4'hA, CND_LT = 4'hB,
    CND_GT = 4'hC, CND_LE = 4'hD, CND_AL = 4'hE, CND_NV = 4'hF
  } cond_e;

endpackage

// File: rtl/flagpred_cond_eval.sv
module flagpred_cond_eval
  import flagpred_pkg::*;
#(
  parameter int CW = 4
) (
  input  nzcv_t          flags,
  input  logic [CW-1:0]  code,
  output logic           pass
);
  localparam int PAIR_W = CW - 1;

  logic [PAIR_W-1:0] pair_sel;
  logic              base;
  logic              signed_ok;

  assign pair_sel  = code[CW-1:1];
  assign signed_ok = (flags.n == flags.v);

  // Each code pair shares one base test; the low bit inverts it.
  always_comb begin
    unique case (pair_sel)
      3'd0:    base = flags.z;
      3'd1:    base = flags.c;
      3'd2:    base = flags.n;
      3'd3:    base = flags.v;
      3'd4:    base = flags.c & ~flags.z;
      3'd5:    base = signed_ok;
      3'd6:    base = ~flags.z & signed_ok;
      default: base = 1'b1;
    endcase
  end

  assign pass = base ^ code[0];

endmodule

// File: rtl/flagpred_commit_gate.sv
module flagpred_commit_gate (
  input  logic pass,
  input  logic set_flags,
  input  logic cmp_only,
  output logic commit_en,
  output logic reg_we,
  output logic flag_upd
);
  // A failed condition kills both the register write and the flag load.
  assign commit_en = pass;
  assign reg_we    = pass & ~cmp_only;
  assign flag_upd  = pass & (set_flags | cmp_only);
endmodule

// File: rtl/flagpred_flag_store.sv
module flagpred_flag_store
  import flagpred_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [DW-1:0] result,
  input  logic          carry,
  input  logic          ovf,
  output nzcv_t         flags_q
);
  localparam int MSB = DW - 1;

  nzcv_t flags_d;

  always_comb begin
    flags_d.n = result[MSB];
    flags_d.z = (result == '0);
    flags_d.c = carry;
    flags_d.v = ovf;
  end

  always_ff @(posedge clk) begin
    if (rst)      flags_q <= '0;
    else if (upd) flags_q <= flags_d;
  end

  // R6: a granted update lands the ALU outputs one edge later
  a_r6_load: assert property (@(posedge clk) disable iff (rst)
    upd |=> (flags_q.n == $past(result[MSB])) && (flags_q.z == ($past(result) == '0))
            && (flags_q.c == $past(carry)) && (flags_q.v == $past(ovf)));

  // R10: no update request means the flags hold
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(flags_q));

endmodule

// File: rtl/flagpred_top.sv
module flagpred_top
  import flagpred_pkg::*;
#(
  parameter int IW = 32,
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] instr_word,
  input  logic [DW-1:0] alu_result,
  input  logic          alu_carry,
  input  logic          alu_ovf,
  input  logic          set_flags,
  input  logic          cmp_only,
  output logic [3:0]    flags_o,
  output logic          commit_en,
  output logic          reg_we
);
  localparam int COND_LSB = IW - CW;

  logic [CW-1:0] cond_code;
  nzcv_t         flags_q;
  logic          pass;
  logic          flag_upd;

  assign cond_code = instr_word[IW-1:COND_LSB];
  assign flags_o   = flags_q;

  flagpred_cond_eval #(.CW(CW)) u_eval (
    .flags (flags_q),
    .code  (cond_code),
    .pass  (pass)
  );

  flagpred_commit_gate u_gate (
    .pass      (pass),
    .set_flags (set_flags),
    .cmp_only  (cmp_only),
    .commit_en (commit_en),
    .reg_we    (reg_we),
    .flag_upd  (flag_upd)
  );

  flagpred_flag_store #(.DW(DW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .upd     (flag_upd),
    .result  (alu_result),
    .carry   (alu_carry),
    .ovf     (alu_ovf),
    .flags_q (flags_q)
  );

  // R1: reset clears the flags
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (flags_o == 4'b0000));

  // R4: always and never codes
  a_r4_always_runs: assert property (@(posedge clk) disable iff (rst)
    (cond_code == CND_AL) |-> commit_en);
  a_r4_never_runs: assert property (@(posedge clk) disable iff (rst)
    (cond_code == CND_NV) |-> !commit_en);

  // R5: signed greater-or-equal follows N==V on the output flags
  a_r5_ge: assert property (@(posedge clk) disable iff (rst)
    (cond_code == CND_GE) |-> (commit_en == (flags_o[3] == flags_o[0])));

  // R7: compares never write a register
  a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    cmp_only |-> !reg_we);

  // R8: a register write implies commit
  a_r8_we_needs_commit: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> commit_en);

  // R9: a squashed instruction leaves the flags untouched
  a_r9_squash_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    !commit_en |=> $stable(flags_o));

endmodule

// File: tb/sim_flagpred_top.sv
module sim_flagpred_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_word = '0;
  logic [31:0] alu_result = '0;
  logic        alu_carry = 1'b0;
  logic        alu_ovf = 1'b0;
  logic        set_flags = 1'b0;
  logic        cmp_only = 1'b0;
  logic [3:0]  flags_o;
  logic        commit_en;
  logic        reg_we;

  int checks = 0;
  int failures = 0;
  logic [3:0] mflags = 4'b0000;   // model {N,Z,C,V}
  logic [27:0] filler = 28'h0;

  always #5 clk = ~clk;

  flagpred_top u0 (
    .clk(clk), .rst(rst), .instr_word(instr_word), .alu_result(alu_result),
    .alu_carry(alu_carry), .alu_ovf(alu_ovf), .set_flags(set_flags),
    .cmp_only(cmp_only), .flags_o(flags_o), .commit_en(commit_en), .reg_we(reg_we)
  );

  function automatic logic model_pass(input logic [3:0] code, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (code)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return c;
      4'h3: return !c;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return c && !z;
      4'h9: return !c || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] code);
    if (code >= 4'hE) return "R4";
    if (code >= 4'hA) return "R5";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One instruction: drive at negedge, judge commit before the edge, flags after it.
  task automatic step(input logic [3:0] code, input logic [31:0] res, input logic c, input logic v,
                      input logic sf, input logic cmp, input string req);
    logic exp_pass;
    @(negedge clk);
    instr_word = {code, filler};
    alu_result = res; alu_carry = c; alu_ovf = v;
    set_flags = sf; cmp_only = cmp;
    #1;
    exp_pass = model_pass(code, mflags);
    chk(commit_en == exp_pass, {req, " commit"}, 32'(commit_en), 32'(exp_pass));
    chk(reg_we == (exp_pass && !cmp), {req, " R8 reg_we"}, 32'(reg_we), 32'(exp_pass && !cmp));
    @(posedge clk);
    #1;
    if (exp_pass && (sf || cmp)) mflags = {res[31], res == 0, c, v};
    chk(flags_o == mflags, {req, " flags"}, 32'(flags_o), 32'(mflags));
  endtask

  task automatic load_flags(input logic [3:0] f);
    // AL + set_flags; N and Z never both 1 here
    step(4'hE, f[3] ? 32'h8000_0001 : (f[2] ? 32'h0 : 32'h1), f[1], f[0], 1'b1, 1'b0, "R6 R12");
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(flags_o == 4'b0000, "R1 reset", 32'(flags_o), 32'h0);
  endtask

  task automatic t_cond_sweep();
    for (int f = 0; f < 16; f++) begin
      if (f[3] && f[2]) continue;
      load_flags(4'(f));
      for (int k = 0; k < 16; k++)
        step(4'(k), 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, {tag_of(4'(k)), " R10 sweep"});
    end
  endtask

  task automatic t_compare();
    load_flags(4'b0000);
    // R7: compare updates flags without set_flags, no register write
    step(4'hE, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, "R7 cmp zero");
    step(4'h0, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b1, "R7 cmp eq");
  endtask

  task automatic t_squash();
    load_flags(4'b0100);                        // Z=1
    // R9: NE fails; flag-setting and compare both squashed
    step(4'h1, 32'h8000_0000, 1'b1, 1'b1, 1'b1, 1'b0, "R9 squash set");
    step(4'h1, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 1'b1, "R9 squash cmp");
    step(4'hF, 32'h1, 1'b1, 1'b1, 1'b1, 1'b1, "R9 R4 never");
    chk(flags_o == 4'b0100, "R9 hold", 32'(flags_o), 32'h4);
  endtask

  task automatic t_other_bits();
    load_flags(4'b0010);                        // C=1
    for (int i = 0; i < 6; i++) begin
      filler = 28'(32'h9E37_79B9 * (i + 1));
      step(4'h2, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 CS filler");
      step(4'h3, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 CC filler");
    end
    filler = 28'h0;
  endtask

  task automatic t_back_to_back();
    load_flags(4'b0000);
    // R11: write Z then EQ must commit next cycle; then clear Z, NE must commit
    step(4'hE, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R11 set Z");
    step(4'h0, 32'h5, 1'b0, 1'b0, 1'b1, 1'b0, "R11 eq after");
    step(4'h0, 32'h5, 1'b0, 1'b0, 1'b0, 1'b0, "R11 eq stale");
    step(4'h1, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1, "R11 ne cmp");
    step(4'hB, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 R5 lt after");
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_cond_sweep();
    t_compare();
    t_squash();
    t_other_bits();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule